// File: doc/BRIEF.md
# Compare-Clear Event Timer

This block is an up-counting timer that advances once per enabled cycle. A separate divider supplies that enable. A two-bit mode field picks one of two count styles. In free-running mode the count passes its maximum and wraps to zero. In clear-on-compare mode the count returns to zero on the enabled cycle after it equals a compare value, so that value sets the period. An overflow flag and a compare-match flag record events. A waveform level can invert on each match and is gated onto a pin by a direction bit. Each flag drives an interrupt request through its own enable bit.

Software reaches the block through a plain write port with four addresses. The compare value is not double buffered: a write takes effect on the next cycle. A new compare value below the current count is therefore missed, and the count runs through the maximum and wraps before it can match. Flags are cleared by writing ones to the flag address, or by an acknowledge input when the interrupt is serviced.

Top module: `cmp_timer`

## Requirements
- R1: A synchronous reset makes the count, the compare value, the control field, both flags and the waveform level zero, so the pin and both interrupt requests read 0.
- R2: The count changes only on cycles with `tick_i` high or with a count write; with neither it holds its value.
- R3: In mode 0, and in the reserved modes 1 and 3, each tick adds one, the count wraps from 0xFF to 0x00 and a compare match never clears it.
- R4: In every mode, a tick at count 0xFF with no count write sets the overflow flag at the same clock edge that makes the count 0x00. The flag then stays set until it is cleared.
- R5: In mode 2, a tick while the count equals the compare value makes the next count 0x00, so the period is compare+1 ticks.
- R6: A tick while the count equals the compare value, with no count write, sets the compare-match flag at that edge, in any mode.
- R7: A compare write (address 1) is used from the next cycle on. If the new value is below the count, no match occurs until the count wraps through 0xFF to 0x00 and climbs to the value.
- R8: With the wave field (control bits 3:2) equal to 1, the waveform level inverts at every match. With any other value the level holds.
- R9: `wave_pin_o` equals the waveform level when the direction bit (control bit 4) is 1 and is 0 otherwise.
- R10: A count write (address 0) loads `wr_data_i` and overrides the increment in that cycle. It also suppresses that cycle's match and overflow.
- R11: Writing to address 3 clears the overflow flag where data bit 0 is 1 and the match flag where data bit 1 is 1. A high `ovf_ack_i` / `cmp_ack_i` also clears its flag. A hardware set in the same cycle wins over any clear.
- R12: `ovf_irq_o` is the overflow flag AND control bit 5, and `cmp_irq_o` is the match flag AND control bit 6.
- R13: The control write (address 2) takes the mode from data bits 1:0, with mode 2 selecting clear-on-compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Count enable from the prescaler |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | 0 count, 1 compare, 2 control, 3 flag clear |
| wr_data_i | input | CNT_W | Write data |
| ovf_ack_i | input | 1 | Overflow interrupt serviced, clears the flag |
| cmp_ack_i | input | 1 | Match interrupt serviced, clears the flag |
| count_o | output | CNT_W | Current count |
| top_o | output | CNT_W | Current compare value |
| ovf_flag_o | output | 1 | Overflow flag |
| cmp_flag_o | output | 1 | Compare-match flag |
| wave_o | output | 1 | Internal waveform level |
| wave_pin_o | output | 1 | Waveform level gated by the direction bit |
| ovf_irq_o | output | 1 | Overflow interrupt request |
| cmp_irq_o | output | 1 | Compare-match interrupt request |

## Verification
A corrupted count appears on `count_o` at the next edge. It also shifts every later match and wrap, so the flags and the waveform level go wrong within one period. A stale compare value shows up as a clear at the wrong count in mode 2, one period later at most. A flag that is set or cleared wrongly is visible on the flag outputs at the next edge, and on the interrupt lines when the enables are set. The missed-match case needs a full wrap of 224 ticks before the difference shows.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   typedef enum logic [1:0] {
      ADDR_COUNT = 2'd0,
      ADDR_TOP   = 2'd1,
      ADDR_CTRL  = 2'd2,
      ADDR_FLAGS = 2'd3
   } reg_addr_e;

   typedef enum logic [1:0] {
      MODE_FREE  = 2'd0,
      MODE_RSV1  = 2'd1,
      MODE_CLEAR = 2'd2,
      MODE_RSV3  = 2'd3
   } mode_e;

   typedef enum logic [1:0] {
      WAVE_HOLD   = 2'd0,
      WAVE_TOGGLE = 2'd1,
      WAVE_RSV2   = 2'd2,
      WAVE_RSV3   = 2'd3
   } wave_e;

   typedef struct packed {
      logic  cmp_ie;
      logic  ovf_ie;
      logic  pin_dir;
      wave_e wave;
      mode_e mode;
   } ctrl_t;

   localparam int CTRL_W    = $bits(ctrl_t);
   localparam int FLAG_OVF  = 0;
   localparam int FLAG_CMP  = 1;
   localparam int NUM_FLAGS = 2;

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
   import tmr_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 wr_en,
   input  logic [1:0]           wr_addr,
   input  logic [CNT_W-1:0]     wr_data,
   output logic [CNT_W-1:0]     top_q,
   output ctrl_t                ctrl_q,
   output logic                 cnt_wr,
   output logic [NUM_FLAGS-1:0] flag_wclr
);

   reg_addr_e addr;
   assign addr = reg_addr_e'(wr_addr);

   assign cnt_wr = wr_en && (addr == ADDR_COUNT);

   always_comb begin
      flag_wclr = '0;
      if (wr_en && addr == ADDR_FLAGS) begin
         flag_wclr = wr_data[NUM_FLAGS-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         top_q  <= '0;
         ctrl_q <= '0;
      end else if (wr_en) begin
         if (addr == ADDR_TOP) begin
            top_q <= wr_data;
         end
         if (addr == ADDR_CTRL) begin
            ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
         end
      end
   end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   input  logic             cnt_wr,
   input  logic [CNT_W-1:0] cnt_wdata,
   input  logic [CNT_W-1:0] top,
   input  logic             clear_mode,
   output logic [CNT_W-1:0] count,
   output logic             match_ev,
   output logic             wrap_ev
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic live;

   assign live     = tick && !cnt_wr;
   assign match_ev = live && (count == top);
   assign wrap_ev  = live && (count == CNT_MAX);

   always_ff @(posedge clk) begin
      if (rst) begin
         count <= '0;
      end else if (cnt_wr) begin
         count <= cnt_wdata;
      end else if (live) begin
         if (clear_mode && match_ev) begin
            count <= '0;
         end else begin
            count <= count + CNT_ONE;
         end
      end
   end

endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
   input  logic clk,
   input  logic rst,
   input  logic set,
   input  logic clr,
   output logic q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         q <= 1'b0;
      end else if (set) begin
         q <= 1'b1;
      end else if (clr) begin
         q <= 1'b0;
      end
   end

endmodule

// File: rtl/tmr_wave.sv
module tmr_wave #(
   parameter bit PIN_GATED = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic match_ev,
   input  logic toggle_en,
   input  logic pin_dir,
   output logic level,
   output logic pin
);

   always_ff @(posedge clk) begin
      if (rst) begin
         level <= 1'b0;
      end else if (match_ev && toggle_en) begin
         level <= ~level;
      end
   end

   generate
      if (PIN_GATED) begin : g_gated
         assign pin = level & pin_dir;
      end else begin : g_direct
         logic unused_dir;
         assign unused_dir = pin_dir;
         assign pin = level;
      end
   endgenerate

endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
   import tmr_pkg::*;
#(
   parameter int CNT_W     = 8,
   parameter bit PIN_GATED = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             tick_i,
   input  logic             wr_en_i,
   input  logic [1:0]       wr_addr_i,
   input  logic [CNT_W-1:0] wr_data_i,
   input  logic             ovf_ack_i,
   input  logic             cmp_ack_i,
   output logic [CNT_W-1:0] count_o,
   output logic [CNT_W-1:0] top_o,
   output logic             ovf_flag_o,
   output logic             cmp_flag_o,
   output logic             wave_o,
   output logic             wave_pin_o,
   output logic             ovf_irq_o,
   output logic             cmp_irq_o
);

   generate
      if (CNT_W < CTRL_W || CNT_W > 32) begin : g_bad_width
         $error("cmp_timer: CNT_W must lie between CTRL_W and 32");
      end
   endgenerate

   ctrl_t                ctrl_q;
   logic                 cnt_wr;
   logic [NUM_FLAGS-1:0] flag_wclr;
   logic [NUM_FLAGS-1:0] flag_set;
   logic [NUM_FLAGS-1:0] flag_clr;
   logic [NUM_FLAGS-1:0] flag_q;
   logic [NUM_FLAGS-1:0] flag_ie;
   logic [NUM_FLAGS-1:0] ack;
   logic                 match_ev;
   logic                 wrap_ev;

   tmr_regs #(.CNT_W(CNT_W)) u_regs (
      .clk       (clk_i),
      .rst       (rst_i),
      .wr_en     (wr_en_i),
      .wr_addr   (wr_addr_i),
      .wr_data   (wr_data_i),
      .top_q     (top_o),
      .ctrl_q    (ctrl_q),
      .cnt_wr    (cnt_wr),
      .flag_wclr (flag_wclr)
   );

   tmr_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk_i),
      .rst        (rst_i),
      .tick       (tick_i),
      .cnt_wr     (cnt_wr),
      .cnt_wdata  (wr_data_i),
      .top        (top_o),
      .clear_mode (ctrl_q.mode == MODE_CLEAR),
      .count      (count_o),
      .match_ev   (match_ev),
      .wrap_ev    (wrap_ev)
   );

   assign flag_set[FLAG_OVF] = wrap_ev;
   assign flag_set[FLAG_CMP] = match_ev;
   assign ack[FLAG_OVF]      = ovf_ack_i;
   assign ack[FLAG_CMP]      = cmp_ack_i;
   assign flag_ie[FLAG_OVF]  = ctrl_q.ovf_ie;
   assign flag_ie[FLAG_CMP]  = ctrl_q.cmp_ie;
   assign flag_clr           = flag_wclr | ack;

   generate
      for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
         tmr_flag u_flag (
            .clk (clk_i),
            .rst (rst_i),
            .set (flag_set[i]),
            .clr (flag_clr[i]),
            .q   (flag_q[i])
         );
      end
   endgenerate

   assign ovf_flag_o = flag_q[FLAG_OVF];
   assign cmp_flag_o = flag_q[FLAG_CMP];
   assign ovf_irq_o  = flag_q[FLAG_OVF] & flag_ie[FLAG_OVF];
   assign cmp_irq_o  = flag_q[FLAG_CMP] & flag_ie[FLAG_CMP];

   tmr_wave #(.PIN_GATED(PIN_GATED)) u_wave (
      .clk       (clk_i),
      .rst       (rst_i),
      .match_ev  (match_ev),
      .toggle_en (ctrl_q.wave == WAVE_TOGGLE),
      .pin_dir   (ctrl_q.pin_dir),
      .level     (wave_o),
      .pin       (wave_pin_o)
   );

endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk
   import tmr_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst,
   input logic             tick,
   input logic             cnt_wr,
   input logic [CNT_W-1:0] wr_data,
   input ctrl_t            ctrl,
   input logic [CNT_W-1:0] count,
   input logic [CNT_W-1:0] top,
   input logic             ovf_flag,
   input logic             cmp_flag,
   input logic             wave,
   input logic             wave_pin,
   input logic             ovf_irq,
   input logic             cmp_irq
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   a_r1_reset_count: assert property (@(posedge clk)
      rst |=> (count == '0 && !ovf_flag && !cmp_flag && !wave));

   a_r2_hold: assert property (@(posedge clk) disable iff (rst)
      (!tick && !cnt_wr) |=> $stable(count));

   a_r3_free_inc: assert property (@(posedge clk) disable iff (rst)
      (tick && !cnt_wr && ctrl.mode != MODE_CLEAR)
      |=> count == $past(count) + CNT_ONE);

   a_r4_overflow: assert property (@(posedge clk) disable iff (rst)
      (tick && !cnt_wr && count == CNT_MAX) |=> (ovf_flag && count == '0));

   a_r5_clear: assert property (@(posedge clk) disable iff (rst)
      (tick && !cnt_wr && ctrl.mode == MODE_CLEAR && count == top)
      |=> count == '0);

   a_r6_match_flag: assert property (@(posedge clk) disable iff (rst)
      (tick && !cnt_wr && count == top) |=> cmp_flag);

   a_r8_wave_hold: assert property (@(posedge clk) disable iff (rst)
      (ctrl.wave != WAVE_TOGGLE) |=> $stable(wave));

   a_r8_wave_toggle: assert property (@(posedge clk) disable iff (rst)
      (ctrl.wave == WAVE_TOGGLE && tick && !cnt_wr && count == top)
      |=> wave != $past(wave));

   a_r9_pin_off: assert property (@(posedge clk) disable iff (rst)
      !ctrl.pin_dir |-> !wave_pin);

   a_r10_load: assert property (@(posedge clk) disable iff (rst)
      cnt_wr |=> count == $past(wr_data));

   a_r12_irq: assert property (@(posedge clk) disable iff (rst)
      (ovf_irq |-> ovf_flag) and (cmp_irq |-> cmp_flag));

endmodule

bind cmp_timer cmp_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk_i),
   .rst      (rst_i),
   .tick     (tick_i),
   .cnt_wr   (cnt_wr),
   .wr_data  (wr_data_i),
   .ctrl     (ctrl_q),
   .count    (count_o),
   .top      (top_o),
   .ovf_flag (ovf_flag_o),
   .cmp_flag (cmp_flag_o),
   .wave     (wave_o),
   .wave_pin (wave_pin_o),
   .ovf_irq  (ovf_irq_o),
   .cmp_irq  (cmp_irq_o)
);

// File: tb/cmp_timer_tb.sv
module cmp_timer_tb;

   localparam int CLK_PERIOD = 10;
   localparam int VEC_W      = 22;
   localparam int NVEC       = 14;

   // {wr, addr[1:0], data[7:0], tick, exp_count[7:0], exp_ovf, exp_cmp}
   localparam logic [VEC_W-1:0] VECS [NVEC] = '{
      {1'b1, 2'd0, 8'hFD, 1'b0, 8'hFD, 1'b0, 1'b0},  // R10 load
      {1'b0, 2'd0, 8'h00, 1'b1, 8'hFE, 1'b0, 1'b0},  // R3
      {1'b0, 2'd0, 8'h00, 1'b1, 8'hFF, 1'b0, 1'b0},  // R3
      {1'b0, 2'd0, 8'h00, 1'b1, 8'h00, 1'b1, 1'b0},  // R4 wrap
      {1'b0, 2'd0, 8'h00, 1'b1, 8'h01, 1'b1, 1'b1},  // R6 match in mode 0, no clear
      {1'b0, 2'd0, 8'h00, 1'b0, 8'h01, 1'b1, 1'b1},  // R2 hold
      {1'b1, 2'd3, 8'h03, 1'b0, 8'h01, 1'b0, 1'b0},  // R11 clear both
      {1'b1, 2'd1, 8'h03, 1'b1, 8'h02, 1'b0, 1'b0},  // R7 top=3
      {1'b1, 2'd2, 8'h02, 1'b1, 8'h03, 1'b0, 1'b0},  // R13 mode 2
      {1'b0, 2'd0, 8'h00, 1'b1, 8'h00, 1'b0, 1'b1},  // R5 clear
      {1'b0, 2'd0, 8'h00, 1'b1, 8'h01, 1'b0, 1'b1},  // R5
      {1'b0, 2'd0, 8'h00, 1'b1, 8'h02, 1'b0, 1'b1},  // R5
      {1'b0, 2'd0, 8'h00, 1'b1, 8'h03, 1'b0, 1'b1},  // R5
      {1'b0, 2'd0, 8'h00, 1'b1, 8'h00, 1'b0, 1'b1}   // R5 period 4
   };

   logic       clk = 1'b0;
   logic       rst;
   logic       tick;
   logic       wr_en;
   logic [1:0] wr_addr;
   logic [7:0] wr_data;
   logic       ovf_ack;
   logic       cmp_ack;
   logic [7:0] count;
   logic [7:0] top;
   logic       ovf_flag, cmp_flag, wave, wave_pin, ovf_irq, cmp_irq;

   int n_checks = 0;
   int n_fail   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cmp_timer #(.CNT_W(8)) u_dut (
      .clk_i      (clk),
      .rst_i      (rst),
      .tick_i     (tick),
      .wr_en_i    (wr_en),
      .wr_addr_i  (wr_addr),
      .wr_data_i  (wr_data),
      .ovf_ack_i  (ovf_ack),
      .cmp_ack_i  (cmp_ack),
      .count_o    (count),
      .top_o      (top),
      .ovf_flag_o (ovf_flag),
      .cmp_flag_o (cmp_flag),
      .wave_o     (wave),
      .wave_pin_o (wave_pin),
      .ovf_irq_o  (ovf_irq),
      .cmp_irq_o  (cmp_irq)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step(input logic w, input logic [1:0] a, input logic [7:0] d,
                       input logic t, input logic oa, input logic ca);
      @(negedge clk);
      wr_en = w; wr_addr = a; wr_data = d; tick = t; ovf_ack = oa; cmp_ack = ca;
      @(posedge clk);
      #1;
      wr_en = 1'b0; tick = 1'b0; ovf_ack = 1'b0; cmp_ack = 1'b0;
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 1'b0);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      step(1'b1, a, d, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      rst = 1'b1; tick = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
      ovf_ack = 1'b0; cmp_ack = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      chk("R1 count", count, 0);
      chk("R1 top", top, 0);
      chk("R1 flags", {ovf_flag, cmp_flag}, 0);
      chk("R1 wave/pin/irq", {wave, wave_pin, ovf_irq, cmp_irq}, 0);

      // vector table
      for (int v = 0; v < NVEC; v++) begin
         step(VECS[v][21], VECS[v][20:19], VECS[v][18:11], VECS[v][10], 1'b0, 1'b0);
         chk($sformatf("R2-table vec%0d count", v), count, VECS[v][9:2]);
         chk($sformatf("R4 R6 table vec%0d flags", v), {ovf_flag, cmp_flag}, VECS[v][1:0]);
      end

      // R11 clear match flag by write
      wr(2'd3, 8'h02);
      chk("R11 write clear", cmp_flag, 0);

      // R7 missed match after lowering top
      wr(2'd1, 8'h10);
      wr(2'd0, 8'h20);
      wr(2'd1, 8'h05);
      wr(2'd3, 8'h03);
      run(224);
      chk("R7 wrap count", count, 0);
      chk("R7 no match before wrap", cmp_flag, 0);
      chk("R4 overflow in mode 2", ovf_flag, 1);
      run(5);
      chk("R7 climb count", count, 5);
      chk("R7 still no match", cmp_flag, 0);
      run(1);
      chk("R7 match after wrap count", count, 0);
      chk("R7 match after wrap flag", cmp_flag, 1);

      // R8 / R9 waveform
      wr(2'd3, 8'h03);
      wr(2'd1, 8'h01);
      wr(2'd2, 8'h06);
      run(1);
      chk("R8 no toggle before match", wave, 0);
      run(1);
      chk("R8 toggle on match", wave, 1);
      chk("R9 pin gated off", wave_pin, 0);
      wr(2'd2, 8'h16);
      chk("R9 pin follows level", wave_pin, 1);
      run(2);
      chk("R8 second toggle", wave, 0);
      chk("R9 pin low", wave_pin, 0);
      run(2);
      chk("R8 third toggle", wave, 1);
      wr(2'd2, 8'h1A);
      run(2);
      chk("R8 hold with field 2", wave, 1);
      chk("R9 pin holds", wave_pin, 1);

      // R10 write priority
      wr(2'd1, 8'h05);
      wr(2'd2, 8'h02);
      wr(2'd3, 8'h03);
      step(1'b1, 2'd0, 8'h05, 1'b1, 1'b0, 1'b0);
      chk("R10 load over tick", count, 5);
      chk("R10 match suppressed", cmp_flag, 0);
      run(1);
      chk("R5 clear after load", count, 0);
      chk("R6 match after load", cmp_flag, 1);
      wr(2'd3, 8'h03);
      step(1'b1, 2'd0, 8'hFF, 1'b1, 1'b0, 1'b0);
      chk("R10 overflow suppressed", ovf_flag, 0);
      run(1);
      chk("R4 wrap after load", {ovf_flag, count}, 9'h100);

      // R11 ack and set-wins
      step(1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 1'b0);
      chk("R11 ovf ack clears", ovf_flag, 0);
      wr(2'd0, 8'h05);
      step(1'b1, 2'd3, 8'h02, 1'b1, 1'b0, 1'b0);
      chk("R11 set wins over clear", cmp_flag, 1);
      step(1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b1);
      chk("R11 cmp ack clears", cmp_flag, 0);

      // R12 interrupt gating
      wr(2'd2, 8'h42);
      chk("R12 irq low without flag", cmp_irq, 0);
      wr(2'd0, 8'h05);
      run(1);
      chk("R12 cmp irq", {ovf_irq, cmp_irq}, 2'b01);
      wr(2'd2, 8'h02);
      chk("R12 irq masked", cmp_irq, 0);

      // R3 reserved mode counts freely
      wr(2'd2, 8'h03);
      wr(2'd1, 8'h02);
      wr(2'd0, 8'h02);
      run(1);
      chk("R3 reserved mode no clear", count, 3);

      // R1 reset mid-run
      wr(2'd2, 8'h16);
      @(negedge clk) rst = 1'b1;
      @(posedge clk);
      #1 rst = 1'b0;
      chk("R1 reset count/top", {count, top}, 0);
      chk("R1 reset flags/wave", {ovf_flag, cmp_flag, wave, wave_pin}, 0);

      finish_run();
   end

endmodule